// File: doc/BRIEF.md
# Remapping ROM Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge's ROM and RAM arrays. The CPU address space below 0x8000 is ROM, seen through two 16 KB windows. The lower window (0x0000–0x3FFF) always shows bank 0. The upper window (0x4000–0x7FFF) shows a switchable bank. The CPU selects that bank by writing to a register. The mapper forms the physical ROM address from the bank number and the low 14 address bits. It returns the selected read data to the CPU.

The bank register is written through any address in 0x2000–0x3FFF. Only the low five data bits are used, and they are not stored as written. A zero becomes one. Any value from 16 to 31 is moved down by eight, so the stored bank always lies between 1 and 23. When the physical address is formed, the stored number is reduced to the number of banks fitted, so a bank beyond the fitted ROM wraps around. Cartridge RAM occupies 0xA000–0xBFFF as one flat 8 KB region. It has no enable register and no banking. A build without RAM answers every read there with 0xFF and never writes it.

Top module: `remap_bank_mapper`

## Requirements
- R1: After reset the upper window shows bank 1 and the lower window shows bank 0.
- R2: For a CPU address in 0x0000–0x3FFF, romAddr equals the address's low 14 bits, with all bank bits 0, whatever the bank register holds.
- R3: For a CPU address in 0x4000–0x7FFF, romAddr equals the stored bank, reduced modulo ROM_BANKS, placed above the address's low 14 bits (romAddr[ROM_ADDR_W-1:14] = bank mod ROM_BANKS, romAddr[13:0] = cpuAddr[13:0]).
- R4: A write with cpuWrEn high to any address in 0x2000–0x3FFF loads the bank register from cpuWrData[4:0] on that clock edge. Data bits 7:5 are ignored, and a value from 1 to 15 is stored unchanged.
- R5: A written bank value of 0 is stored as 1.
- R6: A written bank value from 16 to 31 is stored as that value minus 8, which gives 8 to 23.
- R7: Writes to 0x0000–0x1FFF and to 0x4000–0x7FFF leave the bank register unchanged.
- R8: A stored bank of ROM_BANKS or above wraps. With 16 banks, a written 25 addresses bank 1 and a written 31 addresses bank 7.
- R9: For an address in 0xA000–0xBFFF, ramSel is 1 and ramAddr equals cpuAddr[12:0]. With RAM fitted, ramWe follows cpuWrEn with no enable gating, ramWrData equals cpuWrData, and rdData equals ramRdData.
- R10: With RAM_PRESENT = 0, rdData is 0xFF in the RAM window and ramWe stays 0.
- R11: rdData equals romRdData for addresses below 0x8000, and 0xFF for addresses outside both the ROM and the RAM windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe |
| romRdData | input | 8 | Data from the ROM array |
| ramRdData | input | 8 | Data from the RAM array |
| romAddr | output | ROM_ADDR_W | Physical ROM address |
| romSel | output | 1 | Address is in the ROM space |
| ramSel | output | 1 | Address is in the RAM window |
| ramAddr | output | 13 | RAM array address |
| ramWe | output | 1 | RAM array write enable |
| ramWrData | output | 8 | RAM array write data |
| rdData | output | 8 | Read data returned to the CPU |

## Verification
The only state in the block is the bank register. A wrong value there shows up on the bank bits of romAddr at the first upper-window read after the write that caused it, one clock edge later. Each remap case is therefore checked by a write followed at once by a read of the upper window. The cases are zero, values above 15, bits above bit 4, and values that wrap past the fitted size. A write that should have been ignored is checked the same way: the previously selected bank must still appear on romAddr. The RAM path holds no state, so any fault in its decode appears on ramSel, ramWe or rdData in the same cycle as the address.

// File: rtl/remap_bank_pkg.sv
package remap_bank_pkg;
  localparam int OFF_W = 14;
  localparam int SEL_W = 5;
  localparam int RAM_OFF_W = 13;

  typedef struct packed {
    logic romHit;
    logic upperWin;
    logic bankWr;
    logic ramHit;
    logic ramWr;
  } ctrl_strobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import remap_bank_pkg::*;
#(
  parameter bit RAM_PRESENT = 1'b1
) (
  input  logic [15:0]  cpuAddr,
  input  logic         cpuWrEn,
  output ctrl_strobe_t strobe
);
  logic romSpace;
  logic ramSpace;

  always_comb begin
    romSpace = (cpuAddr[15] == 1'b0);
    ramSpace = (cpuAddr[15:13] == 3'b101);
    strobe.romHit   = romSpace;
    strobe.upperWin = romSpace && cpuAddr[14];
    strobe.bankWr   = cpuWrEn && romSpace && (cpuAddr[14:13] == 2'b01);
    strobe.ramHit   = ramSpace;
    strobe.ramWr    = cpuWrEn && ramSpace && RAM_PRESENT;
  end
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import remap_bank_pkg::*;
#(
  parameter int ROM_BANKS   = 16,
  parameter bit RAM_PRESENT = 1'b1,
  localparam int BANK_W     = $clog2(ROM_BANKS),
  localparam int ROM_ADDR_W = BANK_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strobe,
  input  logic [OFF_W-1:0]      cpuOff,
  input  logic [7:0]            cpuWrData,
  input  logic [7:0]            romRdData,
  input  logic [7:0]            ramRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_OFF_W-1:0]  ramAddr,
  output logic [7:0]            ramWrData,
  output logic [7:0]            rdData,
  output logic [SEL_W-1:0]      bankCur
);
  logic [SEL_W-1:0]  rawSel;
  logic [SEL_W-1:0]  nextBank;
  logic [SEL_W-1:0]  bankQ;
  logic [BANK_W-1:0] physBank;

  always_comb begin
    rawSel = cpuWrData[SEL_W-1:0];
    if (rawSel == '0)
      nextBank = SEL_W'(1);
    else if (rawSel > SEL_W'(15))
      nextBank = rawSel - SEL_W'(8);
    else
      nextBank = rawSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bankQ <= SEL_W'(1);
    else if (strobe.bankWr)
      bankQ <= nextBank;
  end

  generate
    if (BANK_W <= SEL_W) begin : g_narrowRom
      assign physBank = bankQ[BANK_W-1:0];
    end else begin : g_wideRom
      assign physBank = {{(BANK_W-SEL_W){1'b0}}, bankQ};
    end
  endgenerate

  always_comb begin
    if (strobe.upperWin)
      romAddr = {physBank, cpuOff};
    else
      romAddr = {{BANK_W{1'b0}}, cpuOff};
  end

  assign ramAddr   = cpuOff[RAM_OFF_W-1:0];
  assign ramWrData = cpuWrData;
  assign bankCur   = bankQ;

  always_comb begin
    if (strobe.romHit)
      rdData = romRdData;
    else if (strobe.ramHit && RAM_PRESENT)
      rdData = ramRdData;
    else
      rdData = 8'hFF;
  end
endmodule

// File: rtl/remap_bank_mapper.sv
module remap_bank_mapper
  import remap_bank_pkg::*;
#(
  parameter int ROM_BANKS   = 16,
  parameter bit RAM_PRESENT = 1'b1,
  localparam int ROM_ADDR_W = $clog2(ROM_BANKS) + OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWrEn,
  input  logic [7:0]            romRdData,
  input  logic [7:0]            ramRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  romSel,
  output logic                  ramSel,
  output logic [12:0]           ramAddr,
  output logic                  ramWe,
  output logic [7:0]            ramWrData,
  output logic [7:0]            rdData
);
  ctrl_strobe_t     strobe;
  logic [SEL_W-1:0] bankCur;

  bank_ctrl #(.RAM_PRESENT(RAM_PRESENT)) ctrl (
    .cpuAddr (cpuAddr),
    .cpuWrEn (cpuWrEn),
    .strobe  (strobe)
  );

  bank_datapath #(.ROM_BANKS(ROM_BANKS), .RAM_PRESENT(RAM_PRESENT)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuOff    (cpuAddr[OFF_W-1:0]),
    .cpuWrData (cpuWrData),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .rdData    (rdData),
    .bankCur   (bankCur)
  );

  assign romSel = strobe.romHit;
  assign ramSel = strobe.ramHit;
  assign ramWe  = strobe.ramWr;
endmodule

// File: rtl/remap_bank_mapper_chk.sv
module remap_bank_mapper_chk #(
  parameter int ROM_BANKS   = 16,
  parameter bit RAM_PRESENT = 1'b1,
  localparam int ROM_ADDR_W = $clog2(ROM_BANKS) + 14
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [15:0]           cpuAddr,
  input logic [7:0]            cpuWrData,
  input logic                  cpuWrEn,
  input logic [ROM_ADDR_W-1:0] romAddr,
  input logic                  romSel,
  input logic                  ramSel,
  input logic                  ramWe,
  input logic [7:0]            rdData,
  input logic [4:0]            bankCur
);
  logic selWin;
  assign selWin = cpuWrEn && (cpuAddr[15:13] == 3'b001);

  a_r2_low_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (romSel && !cpuAddr[14]) |-> (romAddr[ROM_ADDR_W-1:14] == '0));

  a_r5_zero_is_one: assert property (@(posedge clk) disable iff (!rstN)
    (selWin && cpuWrData[4:0] == 5'd0) |=> (bankCur == 5'd1));

  a_r6_high_shifted: assert property (@(posedge clk) disable iff (!rstN)
    (selWin && cpuWrData[4]) |=> (bankCur >= 5'd8 && bankCur <= 5'd23));

  a_r4_bank_range: assert property (@(posedge clk) disable iff (!rstN)
    (bankCur != 5'd0) && (bankCur <= 5'd23));

  a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !cpuAddr[15] && cpuAddr[14:13] != 2'b01) |=> $stable(bankCur));

  a_r9_we_in_window: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramSel && cpuWrEn));

  a_r10_no_ram: assert property (@(posedge clk) disable iff (!rstN)
    (!RAM_PRESENT && ramSel) |-> (rdData == 8'hFF && !ramWe));
endmodule

bind remap_bank_mapper remap_bank_mapper_chk #(
  .ROM_BANKS(ROM_BANKS), .RAM_PRESENT(RAM_PRESENT)
) chk (.*);

// File: tb/remap_bank_mapper_test.sv
module remap_bank_mapper_test;
  localparam int NB = 16;
  localparam int AW = $clog2(NB) + 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   cpuAddr = 16'h0000;
  logic [7:0]    cpuWrData = 8'h00;
  logic          cpuWrEn = 1'b0;
  logic [7:0]    romRdData = 8'h00;
  logic [7:0]    ramRdData = 8'h00;
  logic [AW-1:0] romAddr, romAddrN;
  logic          romSel, ramSel, ramWe, romSelN, ramSelN, ramWeN;
  logic [12:0]   ramAddr, ramAddrN;
  logic [7:0]    ramWrData, rdData, ramWrDataN, rdDataN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  remap_bank_mapper #(.ROM_BANKS(NB), .RAM_PRESENT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .romRdData(romRdData), .ramRdData(ramRdData),
    .romAddr(romAddr), .romSel(romSel), .ramSel(ramSel), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramWrData(ramWrData), .rdData(rdData));

  remap_bank_mapper #(.ROM_BANKS(NB), .RAM_PRESENT(1'b0)) uutNoRam (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .romRdData(romRdData), .ramRdData(ramRdData),
    .romAddr(romAddrN), .romSel(romSelN), .ramSel(ramSelN), .ramAddr(ramAddrN),
    .ramWe(ramWeN), .ramWrData(ramWrDataN), .rdData(rdDataN));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expUpper(input logic [7:0] wr, input logic [15:0] a);
    logic [4:0] v;
    v = wr[4:0];
    if (v == 0) v = 1;
    else if (v > 15) v = v - 8;
    return {v % NB, a[13:0]};
  endfunction

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic peekRom(input logic [15:0] a, input string tag, input logic [31:0] exp);
    cpuAddr = a;
    #2;
    check(tag, 32'(romAddr), exp);
  endtask

  task automatic t_reset;
    peekRom(16'h4123, "R1 upper bank after reset", {4'd1, 14'h0123});
    peekRom(16'h0123, "R1 lower bank after reset", 32'h0123);
  endtask

  task automatic t_plain;
    cpuWrite(16'h2000, 8'h05);
    peekRom(16'h7ABC, "R3 R4 bank 5", expUpper(8'h05, 16'h7ABC));
    cpuWrite(16'h3FFF, 8'h0F);
    peekRom(16'h4000, "R4 bank 15", {4'd15, 14'h0});
    cpuWrite(16'h2A55, 8'hE3);
    peekRom(16'h5001, "R4 upper data bits ignored", {4'd3, 14'h1001});
  endtask

  task automatic t_lowFixed;
    peekRom(16'h3FFF, "R2 low window top", 32'h3FFF);
    peekRom(16'h0000, "R2 low window base", 32'h0);
  endtask

  task automatic t_zero;
    cpuWrite(16'h2100, 8'h00);
    peekRom(16'h4002, "R5 zero becomes one", {4'd1, 14'h2});
    cpuWrite(16'h2000, 8'h07);
    cpuWrite(16'h3800, 8'h20);
    peekRom(16'h4002, "R5 low bits zero becomes one", {4'd1, 14'h2});
  endtask

  task automatic t_shift;
    cpuWrite(16'h2000, 8'h10);
    peekRom(16'h4010, "R6 16 becomes 8", {4'd8, 14'h10});
    cpuWrite(16'h2000, 8'h17);
    peekRom(16'h4010, "R6 23 becomes 15", {4'd15, 14'h10});
    cpuWrite(16'h2000, 8'h1F);
    peekRom(16'h4010, "R6 R8 31 becomes 23 wraps 7", {4'd7, 14'h10});
    cpuWrite(16'h2000, 8'h19);
    peekRom(16'h7FFF, "R8 25 becomes 17 wraps 1", expUpper(8'h19, 16'h7FFF));
  endtask

  task automatic t_ignored;
    cpuWrite(16'h2000, 8'h06);
    cpuWrite(16'h1000, 8'h09);
    peekRom(16'h4000, "R7 write below 0x2000 ignored", {4'd6, 14'h0});
    cpuWrite(16'h5000, 8'h09);
    cpuWrite(16'h7FFF, 8'h0B);
    peekRom(16'h4000, "R7 write in upper window ignored", {4'd6, 14'h0});
  endtask

  task automatic t_ram;
    @(negedge clk);
    cpuAddr = 16'hA010; cpuWrData = 8'h3C; cpuWrEn = 1'b1;
    #2;
    check("R9 ramSel", 32'(ramSel), 1);
    check("R9 ramWe", 32'(ramWe), 1);
    check("R9 ramAddr", 32'(ramAddr), 32'h0010);
    check("R9 ramWrData", 32'(ramWrData), 32'h3C);
    check("R10 no ram write", 32'(ramWeN), 0);
    @(negedge clk);
    cpuWrEn = 1'b0; cpuAddr = 16'hBFFF; ramRdData = 8'h5A;
    #2;
    check("R9 ramAddr top", 32'(ramAddr), 32'h1FFF);
    check("R9 read data", 32'(rdData), 32'h5A);
    check("R10 no ram reads FF", 32'(rdDataN), 32'hFF);
    cpuAddr = 16'hC000;
    #2;
    check("R11 outside ramSel", 32'(ramSel), 0);
    check("R11 outside reads FF", 32'(rdData), 32'hFF);
    cpuAddr = 16'h4000; romRdData = 8'h77;
    #2;
    check("R11 rom read data", 32'(rdData), 32'h77);
    check("R11 romSel", 32'(romSel), 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_lowFixed();
    t_zero();
    t_shift();
    t_ignored();
    t_ram();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule